// File: doc/BRIEF.md
# Single-Wire Token Host Bridge

This block sits on the host side of a single-wire, open-drain bus on which every bus bit travels as one asynchronous serial character. The system hands it bytes over a valid/ready stream. Each byte is spread over eight characters, least significant bit first. A one bit becomes the character 0x7F and a zero bit becomes 0x7D. Each character goes out as a start bit, seven data bits (LSB first) and a stop bit, at a rate near 230.4 kBaud. The bridge can also hold the line low for a long wake pulse. Such a pulse is far longer than any low period inside a data character. After the pulse the line is released for a fixed guard time before data may follow.

The receive side runs in the other direction. It synchronises the line, frames characters, maps 0x7F and 0x7D back to bits and packs eight bits into a byte, which it offers on its own valid/ready stream. A character with any other value starts the byte over and pulses an error flag. The same happens when the stop bit is missing. While the bridge is driving the line (data or wake), its receiver is held idle so that it does not decode its own traffic. The system must only request a wake when the far device is asleep, since a wake pulse sent to an awake device breaks its bit synchronisation.

Top module: `swire_bridge`

## Requirements
- R1: While reset is asserted and right after it, the line is released (line_low = 0), tx_ready is 1, rx_valid is 0 and rx_frame_err is 0.
- R2: A byte accepted on the transmit stream goes out as eight characters, bit 0 first. Bit value 1 is sent as 0x7F and bit value 0 as 0x7D. Each character is one low start slot, seven data slots carrying the character LSB first (1 = released, 0 = low) and one released stop slot, each slot CLKS_PER_BIT clock cycles long.
- R3: A byte is accepted at a clock edge where tx_valid and tx_ready are both 1, with wake_req at 0. tx_ready then stays 0 until the stop slot of the eighth character has ended and returns to 1 in the cycle after. While tx_ready is 1 the line is released.
- R4: A wake_req sampled with tx_ready at 1 holds the line low for exactly WAKE_CYCLES clock cycles, starting in the cycle after the request.
- R5: After the wake pulse the line stays released and tx_ready stays 0 for RELEASE_CYCLES cycles. A byte already waiting then starts its first start slot RELEASE_CYCLES + 1 cycles after the pulse ends.
- R6: When wake_req and tx_valid are both 1 while idle, the wake goes first and the byte is sent after the release delay. A wake_req raised while a byte is being sent has no effect.
- R7: Received characters 0x7F and 0x7D are decoded to bits 1 and 0. The bits are packed LSB first, and after every eighth bit the byte appears on rx_data with rx_valid at 1.
- R8: rx_valid stays 1 until a cycle with rx_ready at 1, and then clears. A newer byte completed before that handshake replaces the one held.
- R9: A received character other than 0x7F or 0x7D gives a one-cycle pulse on rx_frame_err and throws away the bits gathered so far toward the current byte.
- R10: While the bridge transmits a byte or runs a wake and its release delay, the receiver produces neither rx_valid nor rx_frame_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Byte to send is present |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can take a byte or a wake request |
| wake_req | input | 1 | Request a wake pulse |
| rx_valid | output | 1 | Received byte is held on rx_data |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | System takes the received byte |
| rx_frame_err | output | 1 | One-cycle pulse on a bad character |
| line_low | output | 1 | Open-drain drive: 1 pulls the bus low, 0 releases it |
| line_in | input | 1 | Level of the bus |

## Verification
The bench sends every byte value through the transmitter and decodes the bus with its own character sampler, so a design that reverses the bit order, swaps the two character codes or miscounts slot length produces wrong bytes. It times the wake pulse and the release gap to the exact cycle, which exposes an off-by-one in either counter or a byte that slips ahead of a pending wake. It injects a bad character in the middle of a byte and then a clean byte: a receiver that keeps the stale bits would deliver a shifted byte too early. It also watches for decoded echoes of the bridge's own traffic and for wake requests that leak into a running frame.

// File: rtl/swire_pkg.sv
// Shared types and constants for the single-wire token bridge.
// Assumes one bus bit per serial character with seven data bits.
package swire_pkg;

    localparam logic [6:0] TOK_ONE  = 7'h7F;
    localparam logic [6:0] TOK_ZERO = 7'h7D;

    typedef enum logic [1:0] {TX_IDLE, TX_WAKE, TX_GUARD, TX_FRAME} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // Character that carries one bus bit
    function automatic logic [6:0] token_char(input logic b);
        return b ? TOK_ONE : TOK_ZERO;
    endfunction

endpackage

// File: rtl/swire_tx.sv
// Transmit side: serialises each byte as eight token characters, LSB first,
// and generates the wake pulse followed by its release guard time.
// Assumes CPB >= 2, WAKE_CYCLES >= 1, RELEASE_CYCLES >= 1.
module swire_tx
    import swire_pkg::*;
#(
    parameter int CPB            = 1085,
    parameter int WAKE_CYCLES    = 15000,
    parameter int RELEASE_CYCLES = 375000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       wake_req,
    output logic       line_low,
    output logic       tx_active
);

    localparam int MAXC = (WAKE_CYCLES > RELEASE_CYCLES)
                        ? ((WAKE_CYCLES > CPB) ? WAKE_CYCLES : CPB)
                        : ((RELEASE_CYCLES > CPB) ? RELEASE_CYCLES : CPB);
    localparam int CW   = $clog2(MAXC + 1);

    tx_state_e       state;
    logic [CW-1:0]   cnt;
    logic [7:0]      shreg;
    logic [6:0]      chr;
    logic [2:0]      bit_idx;
    logic [3:0]      slot;

    assign tx_ready  = (state == TX_IDLE);
    assign tx_active = (state != TX_IDLE);

    // Sequencer for wake pulse, guard delay and character slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            chr      <= '0;
            bit_idx  <= '0;
            slot     <= '0;
            line_low <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (wake_req) begin
                        state    <= TX_WAKE;
                        line_low <= 1'b1;
                        cnt      <= CW'(WAKE_CYCLES - 1);
                    end else if (tx_valid) begin
                        state    <= TX_FRAME;
                        shreg    <= tx_data;
                        chr      <= token_char(tx_data[0]);
                        bit_idx  <= '0;
                        slot     <= '0;
                        line_low <= 1'b1;
                        cnt      <= CW'(CPB - 1);
                    end
                end
                TX_WAKE: begin
                    if (cnt == '0) begin
                        state    <= TX_GUARD;
                        line_low <= 1'b0;
                        cnt      <= CW'(RELEASE_CYCLES - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                TX_GUARD: begin
                    if (cnt == '0) state <= TX_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                TX_FRAME: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt <= CW'(CPB - 1);
                        if (slot == 4'd8) begin
                            if (bit_idx == 3'd7) begin
                                state <= TX_IDLE;
                            end else begin
                                bit_idx  <= bit_idx + 3'd1;
                                slot     <= '0;
                                line_low <= 1'b1;
                                shreg    <= shreg >> 1;
                                chr      <= token_char(shreg[1]);
                            end
                        end else begin
                            slot     <= slot + 4'd1;
                            line_low <= (slot == 4'd7) ? 1'b0 : ~chr[slot[2:0]];
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !line_low);

    // R2
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wake_req) |=> (line_low && !tx_ready));

    // R4
    wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && tx_ready) |=> (line_low && !tx_ready));

endmodule

// File: rtl/swire_rx.sv
// Receive side: synchronises the line, frames characters, maps token
// characters to bits and packs them LSB first into bytes.
// Assumes CPB >= 2 and that the line idles high between characters.
module swire_rx
    import swire_pkg::*;
#(
    parameter int CPB = 1085
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       enable,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_ready,
    output logic       rx_frame_err
);

    localparam int HALF = CPB / 2;
    localparam int CW   = $clog2(CPB + 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [6:0]    chr;
    logic [7:0]    acc;
    logic [2:0]    nbits;
    logic          s1, s2;
    logic          good, bit_val;

    assign good    = s2 && ((chr == TOK_ONE) || (chr == TOK_ZERO));
    assign bit_val = (chr == TOK_ONE);

    // Two-flop synchroniser for the bus level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
        end
    end

    // Character framing, bit decode, byte packing and output hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            cnt          <= '0;
            idx          <= '0;
            chr          <= '0;
            acc          <= '0;
            nbits        <= '0;
            rx_valid     <= 1'b0;
            rx_data      <= '0;
            rx_frame_err <= 1'b0;
        end else begin
            rx_frame_err <= 1'b0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
                nbits <= '0;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (!s2) begin
                            state <= RX_START;
                            cnt   <= CW'(HALF - 1);
                        end
                    end
                    RX_START: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (!s2) begin
                            state <= RX_DATA;
                            cnt   <= CW'(CPB - 1);
                            idx   <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                    RX_DATA: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else begin
                            chr[idx] <= s2;
                            cnt      <= CW'(CPB - 1);
                            if (idx == 3'd6) state <= RX_STOP;
                            else             idx   <= idx + 3'd1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else begin
                            state <= RX_IDLE;
                            if (good) begin
                                acc <= {bit_val, acc[7:1]};
                                if (nbits == 3'd7) begin
                                    rx_data  <= {bit_val, acc[7:1]};
                                    rx_valid <= 1'b1;
                                    nbits    <= '0;
                                end else begin
                                    nbits <= nbits + 3'd1;
                                end
                            end else begin
                                rx_frame_err <= 1'b1;
                                nbits        <= '0;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R8
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    // R10
    echo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rx_frame_err && !$rose(rx_valid)));

    // R9
    err_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> !$rose(rx_valid));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err);

endmodule

// File: rtl/swire_bridge.sv
// Top of the single-wire token host bridge: joins the transmitter and the
// receiver and mutes the receiver while the bridge owns the line.
// Assumes an external pull-up on the bus and a 250 MHz clock by default.
module swire_bridge #(
    parameter int CLKS_PER_BIT   = 1085,
    parameter int WAKE_CYCLES    = 15000,
    parameter int RELEASE_CYCLES = 375000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       wake_req,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_ready,
    output logic       rx_frame_err,
    output logic       line_low,
    input  logic       line_in
);

    logic tx_active;

    swire_tx #(
        .CPB            (CLKS_PER_BIT),
        .WAKE_CYCLES    (WAKE_CYCLES),
        .RELEASE_CYCLES (RELEASE_CYCLES)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .wake_req  (wake_req),
        .line_low  (line_low),
        .tx_active (tx_active)
    );

    swire_rx #(
        .CPB (CLKS_PER_BIT)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .enable       (!tx_active),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .rx_frame_err (rx_frame_err)
    );

endmodule

// File: tb/swire_bridge_tb.sv
`timescale 1ns/1ps
module swire_bridge_tb;

    localparam int CPB = 4;
    localparam int WK  = 40;
    localparam int RL  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       wake_req = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ready = 1'b0;
    logic       rx_frame_err;
    logic       line_low;
    logic       dev_low = 1'b0;
    logic       bus;

    int checks = 0;
    int fails = 0;
    int mon_cnt = 0;
    int err_cnt = 0;
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    assign bus = ~(line_low | dev_low);

    swire_bridge #(
        .CLKS_PER_BIT   (CPB),
        .WAKE_CYCLES    (WK),
        .RELEASE_CYCLES (RL)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .wake_req     (wake_req),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .rx_frame_err (rx_frame_err),
        .line_low     (line_low),
        .line_in      (bus)
    );

    always @(negedge clk) begin
        if (mon_en && (rx_valid || rx_frame_err)) mon_cnt++;
        if (rx_frame_err) err_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic get_char(output logic [6:0] c, output logic stop);
        int t = 0;
        while (bus && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            repeat (CPB) @(negedge clk);
            c[i] = bus;
        end
        repeat (CPB) @(negedge clk);
        stop = bus;
    endtask

    task automatic get_byte(output logic [7:0] b, output int bad);
        logic [6:0] c;
        logic s;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            get_char(c, s);
            if (!s) bad++;
            if (c == 7'h7F)      b[i] = 1'b1;
            else if (c == 7'h7D) b[i] = 1'b0;
            else begin
                b[i] = 1'b0;
                bad++;
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = v;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic dev_char(input logic [6:0] c);
        dev_low = 1'b1;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            dev_low = ~c[i];
            repeat (CPB) @(negedge clk);
        end
        dev_low = 1'b0;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic dev_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) dev_char(v[i] ? 7'h7F : 7'h7D);
    endtask

    task automatic take_rx();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int bad;
        int total_bad;
        int n;
        int g;
        int q;
        int e0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 line", line_low, 0);
        chk("R1 ready", tx_ready, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 err", rx_frame_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after", tx_ready, 1);
        chk("R1 bus idle", bus, 1);

        // R2, R3: every byte value, decoded by the bench sampler
        mon_en = 1'b1;
        total_bad = 0;
        for (int v = 0; v < 256; v++) begin
            send_byte(v[7:0]);
            chk("R3 busy", tx_ready, 0);
            get_byte(b, bad);
            total_bad += bad;
            chk("R2 byte", b, v[7:0]);
            chk("R3 busy in stop", tx_ready, 0);
            repeat (2) @(negedge clk);
            chk("R3 ready after stop", tx_ready, 1);
        end
        chk("R2 framing", total_bad, 0);

        // R4, R5, R6: wake and byte together, wake goes first
        @(negedge clk);
        wake_req = 1'b1;
        tx_valid = 1'b1;
        tx_data  = 8'hA5;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R6 wake first", tx_ready, 0);
        n = 0;
        while (!bus && n < 10000) begin
            n++;
            @(negedge clk);
        end
        chk("R4 wake length", n, WK);
        chk("R5 ready in guard", tx_ready, 0);
        g = 0;
        while (bus && g < 10000) begin
            g++;
            @(negedge clk);
        end
        tx_valid = 1'b0;
        chk("R5 guard gap", g, RL + 1);
        get_byte(b, bad);
        chk("R6 byte after wake", b, 8'hA5);
        chk("R6 byte framing", bad, 0);

        // R6: wake request during a frame is ignored
        repeat (4) @(negedge clk);
        send_byte(8'h3C);
        fork
            get_byte(b, bad);
            begin
                repeat (10) @(negedge clk);
                wake_req = 1'b1;
                @(negedge clk);
                wake_req = 1'b0;
            end
        join
        chk("R6 frame intact", b, 8'h3C);
        q = 0;
        repeat (60) @(negedge clk) if (!bus) q++;
        chk("R6 no late wake", q, 0);
        chk("R6 ready", tx_ready, 1);

        // R10: no echo decoded during all own traffic
        chk("R10 echo", mon_cnt, 0);
        mon_en = 1'b0;

        // R7, R8: receive sweep
        for (int v = 0; v < 256; v += 3) begin
            dev_byte(v[7:0]);
            repeat (2) @(negedge clk);
            chk("R7 valid", rx_valid, 1);
            chk("R7 data", rx_data, v[7:0]);
            take_rx();
            chk("R8 clear", rx_valid, 0);
        end

        // R8: hold without ready, then newer byte replaces
        dev_byte(8'h5A);
        repeat (30) @(negedge clk);
        chk("R8 hold", rx_valid, 1);
        chk("R8 hold data", rx_data, 8'h5A);
        dev_byte(8'h81);
        repeat (2) @(negedge clk);
        chk("R8 replace", rx_data, 8'h81);
        take_rx();

        // R9: bad character mid-byte discards partial bits
        e0 = err_cnt;
        dev_char(7'h7F);
        dev_char(7'h7D);
        dev_char(7'h7F);
        dev_char(7'h55);
        repeat (2) @(negedge clk);
        chk("R9 err pulse", err_cnt - e0, 1);
        chk("R9 no byte", rx_valid, 0);
        dev_byte(8'hC3);
        repeat (2) @(negedge clk);
        chk("R9 clean byte valid", rx_valid, 1);
        chk("R9 clean byte", rx_data, 8'hC3);
        chk("R9 single err", err_cnt - e0, 1);
        take_rx();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule